// File: doc/BRIEF.md
# Shadow-Restore Pipeline Hold Controller

This block holds the state of a three-stage pipeline (fetch, execute, write back) together with the control that freezes it. Every stage register carries a valid bit and a tag. The tag identifies the instruction, and here it is the fetch address it came from. A fetch pointer picks the next address. The pointer and each stage register have a shadow copy. On every ordinary clock edge, the shadow copy takes the value the live register had during the cycle that just ended.

A stall or an exception request cannot gate the stage enables in the cycle it shows up. Instead, that edge still loads the stage registers, but with their valid bits cleared, and the shadows keep the state of the interrupted cycle. On the next edge the live registers are reloaded from the shadows. They then stay unchanged for as long as a request is present. When the requests drop, the pipeline advances again from the restored state. Each fetched instruction reaches write back exactly once, in address order.

A write-back strobe is registered on each edge that advances the pipeline while the write-back stage holds a valid entry. Edges that invalidate, restore or hold never produce it. The fetch pointer advances only when fetching is enabled. A disabled fetch inserts a bubble, and a bubble never retires.

Top module: `bkup_pipe_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, all three stage valid bits and `retire_valid` are 0 and `fetch_addr` is 0.
- R2: On an ordinary edge (no pending event, pipeline not frozen) with `fetch_en` high, the fetch stage takes valid=1 with tag equal to the old `fetch_addr`, and `fetch_addr` goes up by one. An instruction then moves one stage per ordinary edge, and `retire_valid` with `retire_tag` equal to its tag appears one ordinary edge after it reaches write back.
- R3: On an ordinary edge with `fetch_en` low, `fetch_addr` is unchanged and the fetch stage becomes invalid.
- R4: When `stall_req` is high on an edge while the pipeline runs normally, all three stage valid bits become 0 after that edge and `retire_valid` is 0.
- R5: On the edge after an invalidating edge, `fetch_addr` and every stage valid bit and tag return to the values they held in the cycle the event was raised, whatever the request inputs are then.
- R6: While a request stays high after the restore, `fetch_addr`, the stage contents and the valid bits do not change, and `retire_valid` stays 0.
- R7: A request that is high on the edge leaving the restored cycle freezes the pipeline directly; the valid bits are not cleared a second time.
- R8: Once the requests drop, the pipeline advances from the restored state. Retired tags run 0, 1, 2, … with no tag skipped or repeated, so after a drain the next expected tag equals `fetch_addr`.
- R9: `excp_req` has the same effect as `stall_req`, and either one alone starts the sequence.
- R10: `retire_valid` is raised only for a write-back entry whose valid bit is 1; bubbles never retire.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_en | input | 1 | Fetch a new instruction on the next ordinary edge |
| stall_req | input | 1 | Stall request, acted on one edge late |
| excp_req | input | 1 | Exception request, acted on one edge late |
| fetch_addr | output | TAG_W | Next fetch address |
| if_valid | output | 1 | Fetch stage valid |
| if_tag | output | TAG_W | Fetch stage tag |
| ex_valid | output | 1 | Execute stage valid |
| ex_tag | output | TAG_W | Execute stage tag |
| wb_valid | output | 1 | Write-back stage valid |
| wb_tag | output | TAG_W | Write-back stage tag |
| retire_valid | output | 1 | Registered write-back strobe |
| retire_tag | output | TAG_W | Tag of the instruction written back |

## Verification
The freeze sequence is driven with one-cycle, two-cycle and multi-cycle requests. One- and two-cycle requests both end after a single restore. A request of three or more cycles catches the restored cycle and has to freeze without a second invalidate. Each pattern is run with stalls and with exceptions, and also back to back, where a second request arrives in the first cycle after a resume. Runs with gaps in the fetch enable check that bubbles keep their place across a restore and never retire. A continuous monitor of the retired tags shows whether any instruction is dropped or written back twice.

// File: rtl/bkup_pipe_pkg.sv
package bkup_pipe_pkg;

  localparam int PIPE_STAGES = 3;
  localparam int SLOTS       = PIPE_STAGES + 1;
  localparam int PTR_IDX     = 0;
  localparam int IF_IDX      = 1;
  localparam int EX_IDX      = 2;
  localparam int WB_IDX      = 3;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'd0,
    ST_INVAL   = 2'd1,
    ST_RESTORE = 2'd2,
    ST_HOLD    = 2'd3
  } pipe_st_e;

  typedef enum logic [1:0] {
    OP_ADV  = 2'd0,
    OP_KILL = 2'd1,
    OP_LOAD = 2'd2,
    OP_KEEP = 2'd3
  } slot_op_e;

endpackage

// File: rtl/bkup_pipe_slot.sv
module bkup_pipe_slot
  import bkup_pipe_pkg::*;
#(
  parameter int   TAG_W = 16,
  parameter logic RST_V = 1'b0
) (
  input  logic             clk,
  input  logic             rst,
  input  slot_op_e         op,
  input  logic             nxt_v,
  input  logic [TAG_W-1:0] nxt_tag,
  output logic             cur_v,
  output logic [TAG_W-1:0] cur_tag
);

  logic             bak_v;
  logic [TAG_W-1:0] bak_tag;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_v   <= RST_V;
      cur_tag <= '0;
      bak_v   <= RST_V;
      bak_tag <= '0;
    end else begin
      case (op)
        OP_ADV: begin
          cur_v   <= nxt_v;
          cur_tag <= nxt_tag;
          bak_v   <= cur_v;
          bak_tag <= cur_tag;
        end
        OP_KILL: begin
          cur_v   <= 1'b0;
          cur_tag <= nxt_tag;
          bak_v   <= cur_v;
          bak_tag <= cur_tag;
        end
        OP_LOAD: begin
          cur_v   <= bak_v;
          cur_tag <= bak_tag;
        end
        OP_KEEP: begin
          cur_v   <= cur_v;
          cur_tag <= cur_tag;
        end
      endcase
    end
  end

endmodule

// File: rtl/bkup_pipe_fsm.sv
module bkup_pipe_fsm
  import bkup_pipe_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     event_req,
  output pipe_st_e st_q,
  output slot_op_e op
);

  pipe_st_e st_d;

  always_comb begin
    st_d = st_q;
    op   = OP_ADV;
    case (st_q)
      ST_NORMAL: begin
        if (event_req) begin
          op   = OP_KILL;
          st_d = ST_INVAL;
        end
      end
      ST_INVAL: begin
        op   = OP_LOAD;
        st_d = ST_RESTORE;
      end
      ST_RESTORE, ST_HOLD: begin
        if (event_req) begin
          op   = OP_KEEP;
          st_d = ST_HOLD;
        end else begin
          op   = OP_ADV;
          st_d = ST_NORMAL;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_NORMAL;
    else     st_q <= st_d;
  end

endmodule

// File: rtl/bkup_pipe_ctrl.sv
module bkup_pipe_ctrl
  import bkup_pipe_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fetch_en,
  input  logic             stall_req,
  input  logic             excp_req,
  output logic [TAG_W-1:0] fetch_addr,
  output logic             if_valid,
  output logic [TAG_W-1:0] if_tag,
  output logic             ex_valid,
  output logic [TAG_W-1:0] ex_tag,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag,
  output logic             retire_valid,
  output logic [TAG_W-1:0] retire_tag
);

  pipe_st_e         st_q;
  slot_op_e         op;
  logic             event_req;
  logic             cur_v   [SLOTS];
  logic [TAG_W-1:0] cur_tag [SLOTS];
  logic             nxt_v   [SLOTS];
  logic [TAG_W-1:0] nxt_tag [SLOTS];

  assign event_req = stall_req | excp_req;

  bkup_pipe_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .event_req (event_req),
    .st_q      (st_q),
    .op        (op)
  );

  // Next-state values for an advancing edge: pointer, then a shift chain.
  always_comb begin
    nxt_v[PTR_IDX]   = 1'b1;
    nxt_tag[PTR_IDX] = cur_tag[PTR_IDX] + TAG_W'(fetch_en);
    nxt_v[IF_IDX]    = fetch_en & cur_v[PTR_IDX];
    nxt_tag[IF_IDX]  = cur_tag[PTR_IDX];
    for (int i = IF_IDX + 1; i < SLOTS; i++) begin
      nxt_v[i]   = cur_v[i-1];
      nxt_tag[i] = cur_tag[i-1];
    end
  end

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    if (g == PTR_IDX) begin : g_ptr
      bkup_pipe_slot #(.TAG_W(TAG_W), .RST_V(1'b1)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .nxt_v   (nxt_v[g]),
        .nxt_tag (nxt_tag[g]),
        .cur_v   (cur_v[g]),
        .cur_tag (cur_tag[g])
      );
    end else begin : g_stage
      bkup_pipe_slot #(.TAG_W(TAG_W), .RST_V(1'b0)) u_slot (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .nxt_v   (nxt_v[g]),
        .nxt_tag (nxt_tag[g]),
        .cur_v   (cur_v[g]),
        .cur_tag (cur_tag[g])
      );
    end
  end

  // Write back happens only on advancing edges, and only for valid entries.
  always_ff @(posedge clk) begin
    if (rst) begin
      retire_valid <= 1'b0;
      retire_tag   <= '0;
    end else begin
      retire_valid <= (op == OP_ADV) && cur_v[WB_IDX];
      retire_tag   <= cur_tag[WB_IDX];
    end
  end

  assign fetch_addr = cur_tag[PTR_IDX];
  assign if_valid   = cur_v[IF_IDX];
  assign if_tag     = cur_tag[IF_IDX];
  assign ex_valid   = cur_v[EX_IDX];
  assign ex_tag     = cur_tag[EX_IDX];
  assign wb_valid   = cur_v[WB_IDX];
  assign wb_tag     = cur_tag[WB_IDX];

endmodule

// File: rtl/bkup_pipe_chk.sv
module bkup_pipe_chk
  import bkup_pipe_pkg::*;
#(
  parameter int TAG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             fetch_en,
  input logic             stall_req,
  input logic             excp_req,
  input pipe_st_e         st_q,
  input logic [TAG_W-1:0] fetch_addr,
  input logic             if_valid,
  input logic [TAG_W-1:0] if_tag,
  input logic             ex_valid,
  input logic [TAG_W-1:0] ex_tag,
  input logic             wb_valid,
  input logic [TAG_W-1:0] wb_tag,
  input logic             retire_valid,
  input logic [TAG_W-1:0] retire_tag
);

  logic             ev;
  logic             seen_q;
  logic [TAG_W-1:0] last_q;

  assign ev = stall_req | excp_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= 1'b0;
      last_q <= '0;
    end else if (retire_valid) begin
      seen_q <= 1'b1;
      last_q <= retire_tag;
    end
  end

  AST_FETCH_ADVANCE: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORMAL && !ev && fetch_en) |=> (if_valid && if_tag == $past(fetch_addr))); // R2

  AST_BUBBLE_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORMAL && !ev && !fetch_en) |=> ($stable(fetch_addr) && !if_valid)); // R3

  AST_EVENT_INVALIDATES: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_NORMAL && ev) |=> (!if_valid && !ex_valid && !wb_valid && !retire_valid)); // R4

  AST_RESTORE_MATCHES: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_INVAL) |=> (fetch_addr == $past(fetch_addr, 2) &&
                            if_valid == $past(if_valid, 2) && if_tag == $past(if_tag, 2) &&
                            ex_valid == $past(ex_valid, 2) && ex_tag == $past(ex_tag, 2) &&
                            wb_valid == $past(wb_valid, 2) && wb_tag == $past(wb_tag, 2))); // R5

  AST_HOLD_FIXED: assert property (@(posedge clk) disable iff (rst)
    ((st_q == ST_RESTORE || st_q == ST_HOLD) && ev) |=>
      ($stable(fetch_addr) && $stable(if_valid) && $stable(if_tag) && $stable(ex_valid) &&
       $stable(ex_tag) && $stable(wb_valid) && $stable(wb_tag) && !retire_valid)); // R6

  AST_NO_SECOND_KILL: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_RESTORE) |=> (st_q != ST_INVAL)); // R7

  AST_FIRST_RETIRE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && !seen_q) |-> (retire_tag == '0)); // R8

  AST_RETIRE_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
    (retire_valid && seen_q) |-> (retire_tag == last_q + TAG_W'(1))); // R8

  AST_RETIRE_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
    retire_valid |-> $past(wb_valid)); // R10

endmodule

bind bkup_pipe_ctrl bkup_pipe_chk #(.TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .fetch_en     (fetch_en),
  .stall_req    (stall_req),
  .excp_req     (excp_req),
  .st_q         (st_q),
  .fetch_addr   (fetch_addr),
  .if_valid     (if_valid),
  .if_tag       (if_tag),
  .ex_valid     (ex_valid),
  .ex_tag       (ex_tag),
  .wb_valid     (wb_valid),
  .wb_tag       (wb_tag),
  .retire_valid (retire_valid),
  .retire_tag   (retire_tag)
);

// File: tb/bkup_pipe_ctrl_bench.sv
module bkup_pipe_ctrl_bench;

  localparam int TAG_W = 16;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             fetch_en = 1'b1;
  logic             stall_req = 1'b0;
  logic             excp_req = 1'b0;
  logic [TAG_W-1:0] fetch_addr, if_tag, ex_tag, wb_tag, retire_tag;
  logic             if_valid, ex_valid, wb_valid, retire_valid;

  int checks = 0;
  int errors = 0;
  int retired = 0;
  bit done = 1'b0;
  logic [TAG_W-1:0] exp_tag = '0;

  always #5 clk = ~clk;

  bkup_pipe_ctrl #(.TAG_W(TAG_W)) u_bkup_pipe_ctrl (
    .clk(clk), .rst(rst), .fetch_en(fetch_en), .stall_req(stall_req), .excp_req(excp_req),
    .fetch_addr(fetch_addr), .if_valid(if_valid), .if_tag(if_tag),
    .ex_valid(ex_valid), .ex_tag(ex_tag), .wb_valid(wb_valid), .wb_tag(wb_tag),
    .retire_valid(retire_valid), .retire_tag(retire_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // R8: every retired tag is the next one in fetch order.
  always @(negedge clk) begin
    if (!rst && retire_valid) begin
      chk(retire_tag == exp_tag, "R8", "retire order", int'(retire_tag), int'(exp_tag));
      exp_tag = exp_tag + 1'b1;
      retired++;
    end
  end

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    chk(!if_valid && !ex_valid && !wb_valid, "R1", "stage valids in reset",
        int'({if_valid, ex_valid, wb_valid}), 0);
    chk(fetch_addr == '0, "R1", "fetch_addr in reset", int'(fetch_addr), 0);
    chk(!retire_valid, "R1", "retire in reset", int'(retire_valid), 0);
    rst = 1'b0;
  endtask

  task automatic t_fill();
    @(negedge clk);
    chk(if_valid && if_tag == '0, "R2", "fetch stage after first edge", int'(if_tag), 0);
    chk(fetch_addr == 1, "R2", "pointer after first edge", int'(fetch_addr), 1);
    chk(!wb_valid && !retire_valid, "R1", "nothing retired right after reset",
        int'({wb_valid, retire_valid}), 0);
    repeat (2) @(negedge clk);
    chk(wb_valid && wb_tag == '0, "R2", "write-back stage tag", int'(wb_tag), 0);
    @(negedge clk);
    chk(retire_valid && retire_tag == '0, "R2", "first retire", int'(retire_tag), 0);
  endtask

  task automatic t_bubble();
    logic [TAG_W-1:0] fa;
    fa = fetch_addr;
    fetch_en = 1'b0;
    @(negedge clk);
    fetch_en = 1'b1;
    chk(fetch_addr == fa, "R3", "pointer holds on bubble", int'(fetch_addr), int'(fa));
    chk(!if_valid, "R3", "fetch stage invalid on bubble", int'(if_valid), 0);
    repeat (3) @(negedge clk);
    chk(!retire_valid, "R10", "bubble does not retire", int'(retire_valid), 0);
  endtask

  task automatic t_stall(input int len, input bit exc);
    logic [TAG_W-1:0] fa, t1, t2, t3;
    logic             v1, v2, v3;
    string            rq;
    rq = exc ? "R9" : "R4";
    fa = fetch_addr; v1 = if_valid; t1 = if_tag;
    v2 = ex_valid;   t2 = ex_tag;   v3 = wb_valid; t3 = wb_tag;
    if (exc) excp_req = 1'b1; else stall_req = 1'b1;
    @(negedge clk);
    chk(!if_valid && !ex_valid && !wb_valid, rq, "valids cleared on event edge",
        int'({if_valid, ex_valid, wb_valid}), 0);
    chk(!retire_valid, rq, "no retire on event edge", int'(retire_valid), 0);
    if (len == 1) begin stall_req = 1'b0; excp_req = 1'b0; end
    @(negedge clk);
    chk(fetch_addr == fa, "R5", "pointer restored", int'(fetch_addr), int'(fa));
    chk({if_valid, if_tag, ex_valid, ex_tag, wb_valid, wb_tag} == {v1, t1, v2, t2, v3, t3},
        "R5", "stages restored", int'(if_tag), int'(t1));
    if (len == 2) begin stall_req = 1'b0; excp_req = 1'b0; end
    for (int k = 3; k <= len; k++) begin
      @(negedge clk);
      chk({if_valid, ex_valid, wb_valid} == {v1, v2, v3}, (k == 3) ? "R7" : "R6",
          "valids kept while frozen", int'({if_valid, ex_valid, wb_valid}), int'({v1, v2, v3}));
      chk(fetch_addr == fa && if_tag == t1 && ex_tag == t2 && wb_tag == t3 && !retire_valid,
          "R6", "state fixed while frozen", int'(fetch_addr), int'(fa));
      if (k == len) begin stall_req = 1'b0; excp_req = 1'b0; end
    end
    @(negedge clk);
    chk(ex_valid == v1 && ex_tag == t1, "R8", "resume from restored state",
        int'(ex_tag), int'(t1));
  endtask

  task automatic t_run(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_drain();
    fetch_en = 1'b0;
    repeat (6) @(negedge clk);
    chk(exp_tag == fetch_addr, "R8", "all fetched retired once", int'(exp_tag), int'(fetch_addr));
    chk(retired > 20, "R8", "enough retired", retired, 21);
    chk(!retire_valid && !wb_valid, "R10", "drained pipe idle",
        int'({retire_valid, wb_valid}), 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_fill();
    t_run(5);
    t_bubble();
    t_stall(1, 1'b0);
    t_stall(1, 1'b0);          // back to back
    t_run(3);
    t_stall(2, 1'b0);
    t_run(2);
    t_stall(5, 1'b0);
    t_run(4);
    t_stall(1, 1'b1);
    t_stall(4, 1'b1);
    // bubbles in flight when the event arrives
    fetch_en = 1'b0; @(negedge clk);
    fetch_en = 1'b1; @(negedge clk);
    fetch_en = 1'b0; @(negedge clk);
    fetch_en = 1'b1;
    t_stall(3, 1'b0);
    t_run(6);
    t_drain();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule